// File: doc/BRIEF.md
# Fractional Cycle-Skipping Baud Clock

This block makes the oversampling base clock for an asynchronous serial port when the wanted bit rate is not an integer division of the peripheral clock. The peripheral clock is halved, and out of every group of 51 halved cycles, 47 are passed on as base-clock pulses and 4 are dropped. The dropped cycles are spread evenly with a running accumulator. Eight base pulses make one serial bit. Each bit therefore lasts 8 or 9 halved cycles, and the long-run average is 47/51 of the halved rate divided by eight. From a 16 MHz clock this gives about 7.3725 MHz of base clock and about 921.569 kbps.

A 4-bit source-select code picks the mode. Only code `0011` runs the generator. Every other code, including `0000` (hand the port back to the plain baud path), keeps it idle with both outputs low. When the block goes idle, because enable falls or the code leaves `0011`, the halving phase, the accumulator and the pulse counter are all cleared. A restart therefore always begins from the same phase.

The control is a three-state machine:
- `ST_IDLE`: generator stopped.
- `ST_HALF`: first clock of a halved cycle.
- `ST_STEP`: second clock, in which the accumulator steps.

The transitions are:
- `ST_IDLE→ST_HALF` (start)
- `ST_HALF→ST_STEP` (half)
- `ST_STEP→ST_HALF` (wrap)
- any state→`ST_IDLE` (stop, when not active)

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs are low after that edge.
- R2: The block is active only when `en` is 1 and `sel` equals 4'b0011. At any edge where it is not active, both outputs are low after that edge.
- R3: Count the edges of an active run from k=0, where k=0 is the first active edge. A base pulse can appear only after an even edge k ≥ 2, and each pulse lasts one clock.
- R4: The edge k=2n closes halved cycle n. A base pulse follows that edge exactly when floor(47·n/51) > floor(47·(n−1)/51). This passes 47 of every 51 halved cycles.
- R5: No two dropped cycles are adjacent. Consecutive base pulses within a run are 2 or 4 clocks apart.
- R6: `bit_tick` is high exactly with a base pulse for which floor(47·n/51) is a multiple of 8, which is every eighth pulse.
- R7: Consecutive bit ticks within a run are 16 or 18 clocks apart (8 or 9 halved cycles).
- R8: After going idle and becoming active again, the pattern restarts. The first base pulse follows edge k=4 and the first tick follows edge k=18.
- R9: At the start of every run the accumulator is zero, so halved cycle 1 is dropped.
- R10: Any 816 consecutive clocks of an active run contain exactly 47 bit ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable |
| sel | input | 4 | Source-select code; 4'b0011 runs the generator |
| base_pulse | output | 1 | One-clock base-clock enable |
| bit_tick | output | 1 | One-clock strobe on every eighth base pulse |

## Verification
Two things can fall in the same cycle. One is a base pulse coinciding with a bit tick. The other is the block dropping out of its active state on the very edge that would have closed a halved cycle.

The bench runs long active stretches, so pulse and tick coincide many times. It also cuts enable or changes the code at random edges, which lands some stops on the step edge. After each edge it compares both outputs against a closed-form model of the floor expressions in R4 and R6. It also checks that a stop always leaves both outputs low and that the next run restarts with the pattern of R8.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HALF = 2'd1,
        ST_STEP = 2'd2
    } phase_t;

    localparam int DEF_KEEP  = 47;
    localparam int DEF_GROUP = 51;
    localparam int DEF_PER_BIT = 8;

endpackage

// File: rtl/frac_baud_phase_fsm.sv
module frac_baud_phase_fsm
    import frac_baud_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic step
);

    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_HALF;
                ST_HALF: state_d = ST_STEP;
                ST_STEP: state_d = ST_HALF;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        step = (state_q == ST_STEP) && active;
    end

endmodule

// File: rtl/frac_baud_skip_acc.sv
module frac_baud_skip_acc #(
    parameter int KEEP  = 47,
    parameter int GROUP = 51
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic keep
);

    localparam int ACC_W = $clog2(GROUP) + 1;
    localparam logic [ACC_W-1:0] KEEP_V  = ACC_W'(KEEP);
    localparam logic [ACC_W-1:0] GROUP_V = ACC_W'(GROUP);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc_q + KEEP_V;
        keep = step && (sum >= GROUP_V);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= keep ? (sum - GROUP_V) : sum;
        end
    end

endmodule

// File: rtl/frac_baud_bit_count.sv
module frac_baud_bit_count #(
    parameter int PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic keep,
    output logic last
);

    localparam int CNT_W = (PER_BIT > 1) ? $clog2(PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        last = keep && (cnt_q == LAST_V);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (keep) begin
            cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter logic [SEL_W-1:0] ACTIVE_CODE = 4'b0011,
    parameter int KEEP    = DEF_KEEP,
    parameter int GROUP   = DEF_GROUP,
    parameter int PER_BIT = DEF_PER_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             base_pulse,
    output logic             bit_tick
);

    logic active;
    logic step;
    logic keep;
    logic last;

    assign active = en && (sel == ACTIVE_CODE);

    frac_baud_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .step   (step)
    );

    frac_baud_skip_acc #(
        .KEEP  (KEEP),
        .GROUP (GROUP)
    ) u_acc (
        .clk  (clk),
        .rst  (rst),
        .clr  (!active),
        .step (step),
        .keep (keep)
    );

    frac_baud_bit_count #(
        .PER_BIT (PER_BIT)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!active),
        .keep (keep),
        .last (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_pulse <= 1'b0;
            bit_tick   <= 1'b0;
        end else begin
            base_pulse <= active && keep;
            bit_tick   <= active && last;
        end
    end

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter logic [3:0] ACTIVE_CODE = 4'b0011
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [3:0] sel,
    input logic       base_pulse,
    input logic       bit_tick
);

    logic       run;
    logic [4:0] pgap;
    logic       pseen;
    logic [5:0] tgap;
    logic       tseen;

    assign run = en && (sel == ACTIVE_CODE);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pgap  <= '0;
            pseen <= 1'b0;
            tgap  <= '0;
            tseen <= 1'b0;
        end else begin
            if (base_pulse) begin
                pgap  <= 5'd1;
                pseen <= 1'b1;
            end else if (pgap != 5'd31) begin
                pgap <= pgap + 5'd1;
            end
            if (bit_tick) begin
                tgap  <= 6'd1;
                tseen <= 1'b1;
            end else if (tgap != 6'd63) begin
                tgap <= tgap + 6'd1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!base_pulse && !bit_tick));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!base_pulse && !bit_tick));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        base_pulse |=> !base_pulse);

    assert_pulse_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (run && base_pulse && pseen) |-> (pgap == 5'd2 || pgap == 5'd4));

    assert_tick_on_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> base_pulse);

    assert_tick_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (run && bit_tick && tseen) |-> (tgap == 6'd16 || tgap == 6'd18));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.ACTIVE_CODE(4'b0011)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sel        (sel),
    .base_pulse (base_pulse),
    .bit_tick   (bit_tick)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] sel = 4'b0000;
    logic       base_pulse;
    logic       bit_tick;

    int n_cmp = 0;
    int n_bad = 0;
    int k = -1;
    bit restarted = 1'b0;
    bit done = 1'b0;
    int last_p = -1;
    int last_t = -1;

    frac_baud_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .sel        (sel),
        .base_pulse (base_pulse),
        .bit_tick   (bit_tick)
    );

    always #5 clk = ~clk;

    function automatic bit exp_pulse(input int kk);
        int n;
        if (kk < 2 || (kk % 2) != 0) return 1'b0;
        n = kk / 2;
        return ((47 * n) / 51) != ((47 * (n - 1)) / 51);
    endfunction

    function automatic bit exp_tick(input int kk);
        if (!exp_pulse(kk)) return 1'b0;
        return (((47 * (kk / 2)) / 51) % 8) == 0;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, expv);
        end
    endtask

    // reference phase counter from the requirement timing
    always @(posedge clk) begin
        if (rst || !(en && sel == 4'b0011)) k = -1;
        else k = k + 1;
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (k < 0) begin
                check(rst ? "R1" : "R2", {31'd0, base_pulse}, 0);
                check(rst ? "R1" : "R2", {31'd0, bit_tick}, 0);
                last_p = -1;
                last_t = -1;
            end else begin
                if (restarted && k <= 18) begin
                    check("R8", {31'd0, base_pulse}, {31'd0, exp_pulse(k)});
                    check("R8", {31'd0, bit_tick}, {31'd0, exp_tick(k)});
                end else if (k <= 2) begin
                    check("R9", {31'd0, base_pulse}, {31'd0, exp_pulse(k)});
                end else if ((k % 2) != 0) begin
                    check("R3", {31'd0, base_pulse}, 0);
                end else begin
                    check("R4", {31'd0, base_pulse}, {31'd0, exp_pulse(k)});
                    check("R6", {31'd0, bit_tick}, {31'd0, exp_tick(k)});
                end
                if (base_pulse) begin
                    if (last_p >= 0)
                        check("R5", ((k - last_p) == 2 || (k - last_p) == 4) ? 1 : 0, 1);
                    last_p = k;
                end
                if (bit_tick) begin
                    if (last_t >= 0)
                        check("R7", ((k - last_t) == 16 || (k - last_t) == 18) ? 1 : 0, 1);
                    last_t = k;
                end
            end
        end
    end

    task automatic run_window;
        int ticks = 0;
        rst = 1'b0; en = 1'b1; sel = 4'b0011;
        repeat (150) @(negedge clk);
        for (int i = 0; i < 816; i++) begin
            @(negedge clk);
            #1;
            if (bit_tick) ticks++;
        end
        check("R10", ticks, 47);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // reset state
        repeat (3) @(negedge clk);
        check("R1", {31'd0, base_pulse}, 0);
        check("R1", {31'd0, bit_tick}, 0);
        // enabled but reset held
        en = 1'b1; sel = 4'b0011;
        repeat (4) @(negedge clk);
        check("R1", {31'd0, base_pulse | bit_tick}, 0);
        // R10 window and first-run phase
        run_window();
        // wrong code with enable high: stays quiet
        sel = 4'b0000;
        repeat (40) @(negedge clk);
        sel = 4'b1011;
        repeat (40) @(negedge clk);
        // R8 restart from idle
        restarted = 1'b1;
        sel = 4'b0011;
        repeat (60) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (200) @(negedge clk);
        // stop on a step edge (k odd before edge means next edge closes a cycle)
        while (!(k >= 0 && (k % 2) == 1)) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (30) @(negedge clk);
        restarted = 1'b0;
        // constrained random segments
        for (int s = 0; s < 80; s++) begin
            int len;
            len = 20 + int'($urandom % 600);
            rst = (($urandom % 20) == 0);
            en  = (($urandom % 100) < 85);
            sel = (($urandom % 100) < 70) ? 4'b0011 : 4'($urandom % 16);
            repeat (len) @(negedge clk);
        end
        rst = 1'b0; en = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule